// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block settles contention between the two ports of a shared memory. Each port presents an active-low enable, a location and an active-low write strobe. When both ports are enabled on the same location, the arbiter decides which port got there first. The other port is flagged busy on its active-low busy pin, and its write is withheld from the array. The arbiter records, on every clock, which port's enable or location changed. That record gives the order of arrival. When both ports change in the same cycle, the left port wins.

A mode input selects how the busy signals behave. In master mode the block makes the busy decision itself. Its write qualification follows that internal decision in the same cycle, whatever level the busy pins show. In slave mode the busy decision arrives from outside on two active-low busy inputs. Each low input blocks writes on its own port, and the busy outputs rest high. A busy port is not stopped from reading, because only its write enable is withheld.

Top module: `busy_arbiter`

## Requirements
- R1: Both busy outputs stay high (1) whenever either enable is high (1 = port deselected) or the two locations differ.
- R2: In master mode, when both ports are enabled on equal locations and only one port's enable or location changed in that cycle, that port is the later arrival. Its busy output goes low (0) after the next rising clock edge, and the other busy output stays high.
- R3: The two busy outputs are never low in the same cycle.
- R4: When both ports' enable or location change in the same cycle and the result is a match, the left port wins and exactly one port, the right, is made busy.
- R5: Once a loser is chosen, it stays busy while the match lasts. Its busy output returns high after the first rising edge at which the locations differ or either enable is high.
- R6: In master mode a port's write enable output is high (1) only when its enable is low, its write strobe is low, and the internal decision in that same cycle does not mark it busy. The busy inputs have no effect in master mode.
- R7: In slave mode both busy outputs stay high after the next edge. A port's write enable is high only when its enable is low, its write strobe is low and its busy input is high; a low busy input blocks that port's write.
- R8: During and right after reset both busy outputs are high, and the arrival record is cleared to "both ports deselected at location 0".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| slaveMode | input | 1 | 1 = busy taken from inputs, 0 = busy generated here |
| lEnN | input | 1 | Left port enable, active low |
| lAddr | input | ADDR_W | Left port location |
| lWrN | input | 1 | Left port write strobe, active low |
| rEnN | input | 1 | Right port enable, active low |
| rAddr | input | ADDR_W | Right port location |
| rWrN | input | 1 | Right port write strobe, active low |
| lBusyInN | input | 1 | Left busy input for slave mode, active low |
| rBusyInN | input | 1 | Right busy input for slave mode, active low |
| lBusyN | output | 1 | Left busy output, active low |
| rBusyN | output | 1 | Right busy output, active low |
| lWrEn | output | 1 | Left write enable to the array, active high |
| rWrEn | output | 1 | Right write enable to the array, active high |

## Verification
A stale arrival record would blame the wrong port. The busy pin would then fall on the earlier port one edge after the match, and the write enables would show the swap in the very cycle the match appears. A loser record that is not cleared would keep a busy pin low one edge past a mismatch, or pull both pins low together. The bench therefore checks the write enables before each edge and the busy pins after it, over sequences where the history decides the result.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Decision strobes from control to datapath: which port is held busy now.
  typedef struct packed {
    logic lBusy;
    logic rBusy;
  } busy_strobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         match,
  input  logic         lChanged,
  input  logic         rChanged,
  output busy_strobe_t dec
);
  busy_strobe_t holdQ;

  // Decide the loser of the current cycle from arrival history.
  always_comb begin
    dec = '0;
    if (match) begin
      if (holdQ.lBusy || holdQ.rBusy) begin
        dec = holdQ;                 // keep the earlier decision while matched
      end else if (lChanged && !rChanged) begin
        dec.lBusy = 1'b1;            // left arrived later
      end else begin
        dec.rBusy = 1'b1;            // right later, or a tie won by left
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdQ <= '0;
    else       holdQ <= dec;
  end

  // R4: on a match exactly one port is the loser
  p_one_loser_r4: assert property (@(posedge clk) disable iff (!rstN)
    match |-> ($countones({dec.lBusy, dec.rBusy}) == 1));

  // R5: a loser stays the loser while the match lasts
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (match && dec.rBusy) ##1 match |-> dec.rBusy);
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              lEnN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrN,
  input  logic              rEnN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrN,
  input  logic              lBusyInN,
  input  logic              rBusyInN,
  input  busy_strobe_t      dec,
  output logic              match,
  output logic              lChanged,
  output logic              rChanged,
  output logic              lBusyN,
  output logic              rBusyN,
  output logic              lWrEn,
  output logic              rWrEn
);
  localparam int TAG_W = ADDR_W + 1;
  localparam logic [TAG_W-1:0] IDLE_TAG = {1'b1, {ADDR_W{1'b0}}};

  logic [TAG_W-1:0] lTag, rTag, lPrevQ, rPrevQ;
  logic lBusyEff, rBusyEff;

  assign lTag = {lEnN, lAddr};
  assign rTag = {rEnN, rAddr};

  assign match    = !lEnN && !rEnN && (lAddr == rAddr);
  assign lChanged = (lTag != lPrevQ);
  assign rChanged = (rTag != rPrevQ);

  // Effective busy for write gating: own decision in master, pins in slave.
  assign lBusyEff = slaveMode ? !lBusyInN : dec.lBusy;
  assign rBusyEff = slaveMode ? !rBusyInN : dec.rBusy;

  assign lWrEn = !lEnN && !lWrN && !lBusyEff;
  assign rWrEn = !rEnN && !rWrN && !rBusyEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lPrevQ <= IDLE_TAG;
      rPrevQ <= IDLE_TAG;
      lBusyN <= 1'b1;
      rBusyN <= 1'b1;
    end else begin
      lPrevQ <= lTag;
      rPrevQ <= rTag;
      lBusyN <= !(dec.lBusy && !slaveMode);
      rBusyN <= !(dec.rBusy && !slaveMode);
    end
  end

  // R3: busy outputs never low together
  p_never_both_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!lBusyN && !rBusyN));

  // R1 / R5: no match means both busy pins high after the edge
  p_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    !match |=> (lBusyN && rBusyN));

  // R6: internal decision blocks writes in master mode
  p_wr_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && (dec.lBusy || dec.rBusy)) |-> !(dec.lBusy && lWrEn) && !(dec.rBusy && rWrEn));

  // R7: low busy input blocks writes in slave mode
  p_slave_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && !lBusyInN) |-> !lWrEn);

  // R7: busy outputs rest high in slave mode
  p_slave_pins_r7: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |=> (lBusyN && rBusyN));
endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              lEnN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWrN,
  input  logic              rEnN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWrN,
  input  logic              lBusyInN,
  input  logic              rBusyInN,
  output logic              lBusyN,
  output logic              rBusyN,
  output logic              lWrEn,
  output logic              rWrEn
);
  busy_strobe_t dec;
  logic match, lChanged, rChanged;

  arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .match    (match),
    .lChanged (lChanged),
    .rChanged (rChanged),
    .dec      (dec)
  );

  arb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .slaveMode (slaveMode),
    .lEnN      (lEnN),
    .lAddr     (lAddr),
    .lWrN      (lWrN),
    .rEnN      (rEnN),
    .rAddr     (rAddr),
    .rWrN      (rWrN),
    .lBusyInN  (lBusyInN),
    .rBusyInN  (rBusyInN),
    .dec       (dec),
    .match     (match),
    .lChanged  (lChanged),
    .rChanged  (rChanged),
    .lBusyN    (lBusyN),
    .rBusyN    (rBusyN),
    .lWrEn     (lWrEn),
    .rWrEn     (rWrEn)
  );
endmodule

// File: tb/busy_arbiter_bench.sv
module busy_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  typedef struct packed {
    logic          slave;
    logic          lEnN;
    logic [AW-1:0] lAddr;
    logic          lWrN;
    logic          rEnN;
    logic [AW-1:0] rAddr;
    logic          rWrN;
    logic          lBin;
    logic          rBin;
    logic          expLWr;
    logic          expRWr;
    logic          expLBusyN;
    logic          expRBusyN;
  } vec_t;

  localparam int NV = 13;
  // slave, lEnN, lAddr, lWrN, rEnN, rAddr, rWrN, lBin, rBin, lWr, rWr, lBusyN, rBusyN
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 10'd5,   1'b0, 1'b1, 10'd5,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // 0 R1 idle
    '{1'b0, 1'b0, 10'd5,   1'b0, 1'b1, 10'd5,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // 1 R1 one side
    '{1'b0, 1'b0, 10'd5,   1'b0, 1'b0, 10'd5,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // 2 R2 right later
    '{1'b0, 1'b0, 10'd5,   1'b0, 1'b0, 10'd5,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // 3 R5 hold
    '{1'b0, 1'b0, 10'd5,   1'b0, 1'b0, 10'd6,   1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // 4 R5 mismatch
    '{1'b0, 1'b0, 10'd6,   1'b0, 1'b0, 10'd6,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // 5 R2 left later
    '{1'b0, 1'b1, 10'd6,   1'b0, 1'b0, 10'd6,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // 6 R5 release
    '{1'b0, 1'b0, 10'd9,   1'b0, 1'b0, 10'd9,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // 7 R4 tie
    '{1'b0, 1'b0, 10'd9,   1'b0, 1'b0, 10'd9,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // 8 R6 inputs ignored
    '{1'b0, 1'b0, 10'd9,   1'b1, 1'b0, 10'd9,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // 9 R6 reads only
    '{1'b0, 1'b0, 10'd9,   1'b1, 1'b1, 10'd9,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // 10 R5 en high
    '{1'b1, 1'b0, 10'd3,   1'b0, 1'b0, 10'd3,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // 11 R7 left blocked
    '{1'b1, 1'b0, 10'd3,   1'b0, 1'b0, 10'd3,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}  // 12 R7 right blocked
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveMode = 1'b0;
  logic lEnN = 1'b1, rEnN = 1'b1, lWrN = 1'b1, rWrN = 1'b1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic lBusyInN = 1'b1, rBusyInN = 1'b1;
  logic lBusyN, rBusyN, lWrEn, rWrEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busy_arbiter #(.ADDR_W(AW)) u_busy_arbiter (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .lEnN(lEnN), .lAddr(lAddr), .lWrN(lWrN),
    .rEnN(rEnN), .rAddr(rAddr), .rWrN(rWrN),
    .lBusyInN(lBusyInN), .rBusyInN(rBusyInN),
    .lBusyN(lBusyN), .rBusyN(rBusyN), .lWrEn(lWrEn), .rWrEn(rWrEn)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic le, input logic [AW-1:0] la, input logic lw,
                       input logic re, input logic [AW-1:0] ra, input logic rw,
                       input logic lb, input logic rb);
    slaveMode = s; lEnN = le; lAddr = la; lWrN = lw;
    rEnN = re; rAddr = ra; rWrN = rw; lBusyInN = lb; rBusyInN = rb;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (2) @(negedge clk);
    check("R8", "lBusyN in reset", lBusyN, 1'b1);
    check("R8", "rBusyN in reset", rBusyN, 1'b1);
    rstN = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R8", "lBusyN after reset", lBusyN, 1'b1);
    check("R8", "rBusyN after reset", rBusyN, 1'b1);

    // Table walk: write enables before the edge, busy pins after it.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].slave, VECS[i].lEnN, VECS[i].lAddr, VECS[i].lWrN,
            VECS[i].rEnN, VECS[i].rAddr, VECS[i].rWrN, VECS[i].lBin, VECS[i].rBin);
      #1;
      check($sformatf("R6/R7 vec%0d", i), "lWrEn", lWrEn, VECS[i].expLWr);
      check($sformatf("R6/R7 vec%0d", i), "rWrEn", rWrEn, VECS[i].expRWr);
      @(posedge clk); #(CLK_PERIOD/4);
      check($sformatf("R1-R5 vec%0d", i), "lBusyN", lBusyN, VECS[i].expLBusyN);
      check($sformatf("R1-R5 vec%0d", i), "rBusyN", rBusyN, VECS[i].expRBusyN);
      check("R3", $sformatf("vec%0d not both low", i), lBusyN | rBusyN, 1'b1);
    end

    // Directed: clear, then left first at top location, right arrives later.
    @(negedge clk); drive(1'b0, 1'b1, '0, 1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); drive(1'b0, 1'b0, 10'h3FF, 1'b0, 1'b1, 10'h3FF, 1'b0, 1'b1, 1'b1);
    @(negedge clk); drive(1'b0, 1'b0, 10'h3FF, 1'b0, 1'b0, 10'h3FF, 1'b0, 1'b1, 1'b1);
    #1;
    check("R6", "top loc right write blocked same cycle", rWrEn, 1'b0);
    check("R6", "top loc left write kept", lWrEn, 1'b1);
    check("R6", "pin not yet low same cycle", rBusyN, 1'b1);
    @(posedge clk); #(CLK_PERIOD/4);
    check("R2", "top loc right busy", rBusyN, 1'b0);
    check("R2", "top loc left free", lBusyN, 1'b1);

    // Directed R8: reset during a held match releases the pin.
    @(negedge clk); rstN = 1'b0; #1;
    check("R8", "reset mid-match rBusyN", rBusyN, 1'b1);
    check("R8", "reset mid-match lBusyN", lBusyN, 1'b1);
    @(negedge clk); rstN = 1'b1;
    // After reset both look changed: tie goes to left, right busy.
    @(posedge clk); #(CLK_PERIOD/4);
    check("R4", "tie after reset rBusyN", rBusyN, 1'b0);
    check("R4", "tie after reset lBusyN", lBusyN, 1'b1);

    // R7: slave mode forces pins high after next edge.
    @(negedge clk); slaveMode = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R7", "slave rBusyN high", rBusyN, 1'b1);
    check("R7", "slave lBusyN high", lBusyN, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule